// File: doc/BRIEF.md
# Power Rail Fault Recovery Controller

This block is the supervisory state machine of a power-management device. It collects per-rail fault flags and sorts every rail into one of three groups: MCU, SoC or other. A flag can mean a power-good window miss, a shorted output or an over-current. The block then reacts according to a two-bit trigger code programmed for each group. A reaction can shut rails down at once or in a short order. It can also blame the MCU domain, or drop only the SoC domain and keep the MCU running.

The controller drives the rail enables for the three groups, both reset outputs, the driver-enable output and two one-cycle interrupt pulses. After a shutdown it waits in a safe state and retries power-up through a retry counter with a programmable limit. Leaving SoC-only operation needs a two-step acknowledge on two sleep pins. A supply-undervoltage input clears everything and holds the block in power-up.

The states are INIT (0), ACTIVE (1), MCU_ONLY (2), SAFE (3) and ORDERLY (4). The transitions are as follows:
- INIT goes to ACTIVE after one cycle.
- ACTIVE or MCU_ONLY goes to SAFE on an immediate or MCU-error reaction.
- ACTIVE or MCU_ONLY goes to ORDERLY on an orderly reaction.
- ACTIVE or MCU_ONLY goes to MCU_ONLY on a SoC-error reaction.
- ORDERLY goes to SAFE.
- SAFE goes to INIT on recovery.
- MCU_ONLY goes to ACTIVE on release.
- Any state goes to INIT on undervoltage.

Top module: `rail_fault_ctrl`

## Requirements
- R1: Reset and undervoltage leave the block in INIT (dev_state 0): all rail enables, both resets, drive_en and both interrupts are low. The cycle after INIT, the state is ACTIVE with all three rail enables high, both resets high and drive_en high.
- R2: A rail is faulty when any of its three flags is set. Its two group bits at rail_grp[2i+1:2i] decode as 00 MCU, 01 SoC, 1x other.
- R3: Each group's trigger code picks its reaction: 00 immediate, 01 orderly, 10 MCU error, 11 SoC error. The new state shows the cycle after the fault is sampled.
- R4: The immediate reaction enters SAFE in one step. It turns MCU and SoC rails off, drives both resets low and drive_en low, and gives a one-cycle irq_mcu_pwr pulse. Other-group rails stay on.
- R5: The MCU-error reaction behaves like the immediate one and also turns off the other-group rails for the whole stay in SAFE.
- R6: The orderly reaction spends exactly one cycle in ORDERLY and then enters SAFE. In ORDERLY, SoC rails are off and soc_rst_n is low, while MCU rails, mcu_rst_n and drive_en stay high.
- R7: The SoC-error reaction enters MCU_ONLY, turns only SoC rails off and gives a one-cycle irq_soc_pwr pulse. It drives soc_rst_n low for exactly SRST_LEN cycles. MCU rails, mcu_rst_n and drive_en do not change.
- R8: MCU_ONLY returns to ACTIVE with SoC rails on only when two things happen in order. First comes one cycle with sleep_a=0 and sleep_b=1. Then, in a later cycle, sleep_a=1. Any other pattern on the sleep pins leaves the state unchanged.
- R9: In SAFE, a sampled cycle with no flag set on any rail recovers to INIT and increments retry_cnt, provided the cycles spent in SAFE are still below rcv_window and retry_cnt is below rcv_limit.
- R10: Once the window has elapsed or retry_cnt has reached rcv_limit, SAFE is held no matter how the faults behave.
- R11: supply_uv, sampled in any state, moves the block to INIT and clears retry_cnt. It wins over every other event and holds INIT while it stays high.
- R12: When faulted groups in the same cycle ask for different reactions, immediate wins over MCU error, which wins over SoC error, which wins over orderly.
- R13: Faults are acted on only in ACTIVE and MCU_ONLY, and only from groups whose rails are on, so SoC-group faults are ignored in MCU_ONLY. A reaction wins over a sleep-pin release in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_pg | input | N_RAILS | Power-good window miss per rail |
| flt_short | input | N_RAILS | Output short per rail |
| flt_ilim | input | N_RAILS | Over-current per rail |
| rail_grp | input | 2*N_RAILS | Group code per rail |
| trig_mcu | input | 2 | Reaction code for MCU group |
| trig_soc | input | 2 | Reaction code for SoC group |
| trig_oth | input | 2 | Reaction code for other group |
| rcv_window | input | WIN_W | Recovery window in cycles |
| rcv_limit | input | CNT_W | Retry limit |
| supply_uv | input | 1 | Supply undervoltage, forces INIT |
| sleep_a | input | 1 | First sleep pin |
| sleep_b | input | 1 | Second sleep pin |
| dev_state | output | 3 | Current state code |
| rail_en_mcu | output | 1 | MCU group rail enable |
| rail_en_soc | output | 1 | SoC group rail enable |
| rail_en_oth | output | 1 | Other group rail enable |
| mcu_rst_n | output | 1 | MCU reset, active low |
| soc_rst_n | output | 1 | SoC reset, active low |
| drive_en | output | 1 | Driver enable |
| irq_mcu_pwr | output | 1 | MCU power-error interrupt pulse |
| irq_soc_pwr | output | 1 | SoC power-error interrupt pulse |
| retry_cnt | output | CNT_W | Recovery attempts taken |

## Verification
Two functions can fall in the same cycle. In MCU_ONLY, the sleep-pin release can coincide with a fault reaction, and faults from several groups with different trigger codes can arrive together. A directed case raises sleep_a after the acknowledge in the very cycle that an MCU-group rail faults. It expects SAFE, not ACTIVE. Further directed cases fault all three groups at once under mixed codes and expect the winning reaction. Random runs then toggle the sleep pins and the faults independently, and a cycle-by-cycle reference model in the bench judges every output.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    typedef enum logic [2:0] {
        ST_INIT     = 3'd0,
        ST_ACTIVE   = 3'd1,
        ST_MCU_ONLY = 3'd2,
        ST_SAFE     = 3'd3,
        ST_ORDERLY  = 3'd4
    } rfc_state_e;

    typedef enum logic [1:0] {
        TRG_IMM = 2'b00,
        TRG_ORD = 2'b01,
        TRG_MCU = 2'b10,
        TRG_SOC = 2'b11
    } rfc_trig_e;

    localparam logic [1:0] GRP_MCU = 2'b00;
    localparam logic [1:0] GRP_SOC = 2'b01;
endpackage

// File: rtl/rfc_fault_arbiter.sv
module rfc_fault_arbiter
    import rfc_pkg::*;
#(
    parameter int N_RAILS = 8
) (
    input  logic [N_RAILS-1:0]   flt_pg,
    input  logic [N_RAILS-1:0]   flt_short,
    input  logic [N_RAILS-1:0]   flt_ilim,
    input  logic [2*N_RAILS-1:0] rail_grp,
    input  logic [1:0]           trig_mcu,
    input  logic [1:0]           trig_soc,
    input  logic [1:0]           trig_oth,
    input  logic                 live_mcu,
    input  logic                 live_soc,
    input  logic                 live_oth,
    output logic                 react_vld,
    output rfc_trig_e            react
);
    logic [N_RAILS-1:0] hit_m, hit_s, hit_o;
    logic               grp_m, grp_s, grp_o;
    logic [3:0]         want;

    generate
        for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
            logic       bad;
            logic [1:0] code;
            assign bad      = flt_pg[i] | flt_short[i] | flt_ilim[i];
            assign code     = rail_grp[2*i +: 2];
            assign hit_m[i] = bad && (code == GRP_MCU);
            assign hit_s[i] = bad && (code == GRP_SOC);
            assign hit_o[i] = bad && code[1];
        end
    endgenerate

    assign grp_m = (|hit_m) && live_mcu;
    assign grp_s = (|hit_s) && live_soc;
    assign grp_o = (|hit_o) && live_oth;

    always_comb begin
        want = 4'b0000;
        if (grp_m) want[trig_mcu] = 1'b1;
        if (grp_s) want[trig_soc] = 1'b1;
        if (grp_o) want[trig_oth] = 1'b1;
        react_vld = |want;
        if (want[TRG_IMM])      react = TRG_IMM;
        else if (want[TRG_MCU]) react = TRG_MCU;
        else if (want[TRG_SOC]) react = TRG_SOC;
        else                    react = TRG_ORD;
    end

    // R12
    always_comb begin
        if (react_vld) begin
            pick_src_chk: assert ((grp_m && trig_mcu == react) ||
                                  (grp_s && trig_soc == react) ||
                                  (grp_o && trig_oth == react));
        end
    end
endmodule

// File: rtl/rfc_retry_ctrl.sv
module rfc_retry_ctrl #(
    parameter int WIN_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_safe,
    input  logic             fault_any,
    input  logic [WIN_W-1:0] rcv_window,
    input  logic [CNT_W-1:0] rcv_limit,
    output logic             recover,
    output logic [CNT_W-1:0] count
);
    logic [WIN_W-1:0] tmr_q;
    logic [CNT_W-1:0] cnt_q;

    assign recover = in_safe && !fault_any && (tmr_q < rcv_window) && (cnt_q < rcv_limit);
    assign count   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            tmr_q <= '0;
            cnt_q <= '0;
        end else begin
            if (!in_safe)          tmr_q <= '0;
            else if (tmr_q != '1)  tmr_q <= tmr_q + 1'b1;
            if (recover && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recover && !clr) |=> count == CNT_W'($past(count) + 1'b1));
    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !recover) |=> count == $past(count));
endmodule

// File: rtl/rfc_reset_pulse.sv
module rfc_reset_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic busy
);
    localparam int PW = $clog2(LEN + 1);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr)          cnt_q <= '0;
        else if (load)         cnt_q <= PW'(LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !clr) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rail_fault_ctrl.sv
module rail_fault_ctrl
    import rfc_pkg::*;
#(
    parameter int N_RAILS  = 8,
    parameter int WIN_W    = 8,
    parameter int CNT_W    = 3,
    parameter int SRST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_RAILS-1:0]   flt_pg,
    input  logic [N_RAILS-1:0]   flt_short,
    input  logic [N_RAILS-1:0]   flt_ilim,
    input  logic [2*N_RAILS-1:0] rail_grp,
    input  logic [1:0]           trig_mcu,
    input  logic [1:0]           trig_soc,
    input  logic [1:0]           trig_oth,
    input  logic [WIN_W-1:0]     rcv_window,
    input  logic [CNT_W-1:0]     rcv_limit,
    input  logic                 supply_uv,
    input  logic                 sleep_a,
    input  logic                 sleep_b,
    output logic [2:0]           dev_state,
    output logic                 rail_en_mcu,
    output logic                 rail_en_soc,
    output logic                 rail_en_oth,
    output logic                 mcu_rst_n,
    output logic                 soc_rst_n,
    output logic                 drive_en,
    output logic                 irq_mcu_pwr,
    output logic                 irq_soc_pwr,
    output logic [CNT_W-1:0]     retry_cnt
);
    rfc_state_e state_q, st_n;
    logic       ack_q, ack_n;
    logic       kill_q, kill_n;
    logic       irqm_q, irqm_n, irqs_q, irqs_n;
    logic       load_p;
    logic       react_vld, recover, pulse_busy, fault_any;
    logic       live_mo, live_soc;
    rfc_trig_e  react;

    assign fault_any = |{flt_pg, flt_short, flt_ilim};
    assign live_mo   = (state_q == ST_ACTIVE) || (state_q == ST_MCU_ONLY);
    assign live_soc  = (state_q == ST_ACTIVE);

    rfc_fault_arbiter #(.N_RAILS(N_RAILS)) u_arb (
        .flt_pg(flt_pg), .flt_short(flt_short), .flt_ilim(flt_ilim),
        .rail_grp(rail_grp), .trig_mcu(trig_mcu), .trig_soc(trig_soc),
        .trig_oth(trig_oth), .live_mcu(live_mo), .live_soc(live_soc),
        .live_oth(live_mo), .react_vld(react_vld), .react(react)
    );

    rfc_retry_ctrl #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(supply_uv),
        .in_safe(state_q == ST_SAFE), .fault_any(fault_any),
        .rcv_window(rcv_window), .rcv_limit(rcv_limit),
        .recover(recover), .count(retry_cnt)
    );

    rfc_reset_pulse #(.LEN(SRST_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .clr(supply_uv), .load(load_p), .busy(pulse_busy)
    );

    // next-state logic
    always_comb begin
        st_n   = state_q;
        ack_n  = ack_q;
        kill_n = kill_q;
        irqm_n = 1'b0;
        irqs_n = 1'b0;
        load_p = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                st_n   = ST_ACTIVE;
                kill_n = 1'b0;
                ack_n  = 1'b0;
            end
            ST_ACTIVE, ST_MCU_ONLY: begin
                if (react_vld) begin
                    unique case (react)
                        TRG_IMM: begin
                            st_n   = ST_SAFE;
                            irqm_n = 1'b1;
                        end
                        TRG_MCU: begin
                            st_n   = ST_SAFE;
                            irqm_n = 1'b1;
                            kill_n = 1'b1;
                        end
                        TRG_SOC: begin
                            st_n   = ST_MCU_ONLY;
                            irqs_n = 1'b1;
                            load_p = 1'b1;
                            ack_n  = 1'b0;
                        end
                        TRG_ORD: st_n = ST_ORDERLY;
                    endcase
                end else if (state_q == ST_MCU_ONLY) begin
                    if (ack_q && sleep_a) begin
                        st_n  = ST_ACTIVE;
                        ack_n = 1'b0;
                    end else if (!sleep_a && sleep_b) begin
                        ack_n = 1'b1;
                    end
                end
            end
            ST_ORDERLY: st_n = ST_SAFE;
            ST_SAFE: if (recover) st_n = ST_INIT;
            default: st_n = ST_INIT;
        endcase
        if (supply_uv) begin
            st_n   = ST_INIT;
            ack_n  = 1'b0;
            kill_n = 1'b0;
            irqm_n = 1'b0;
            irqs_n = 1'b0;
            load_p = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            ack_q   <= 1'b0;
            kill_q  <= 1'b0;
            irqm_q  <= 1'b0;
            irqs_q  <= 1'b0;
        end else begin
            state_q <= st_n;
            ack_q   <= ack_n;
            kill_q  <= kill_n;
            irqm_q  <= irqm_n;
            irqs_q  <= irqs_n;
        end
    end

    // outputs
    always_comb begin
        rail_en_mcu = 1'b0;
        rail_en_soc = 1'b0;
        rail_en_oth = 1'b0;
        mcu_rst_n   = 1'b0;
        soc_rst_n   = 1'b0;
        drive_en    = 1'b0;
        unique case (state_q)
            ST_INIT: ;
            ST_ACTIVE: begin
                rail_en_mcu = 1'b1;
                rail_en_soc = 1'b1;
                rail_en_oth = 1'b1;
                mcu_rst_n   = 1'b1;
                soc_rst_n   = !pulse_busy;
                drive_en    = 1'b1;
            end
            ST_MCU_ONLY: begin
                rail_en_mcu = 1'b1;
                rail_en_oth = 1'b1;
                mcu_rst_n   = 1'b1;
                soc_rst_n   = !pulse_busy;
                drive_en    = 1'b1;
            end
            ST_ORDERLY: begin
                rail_en_mcu = 1'b1;
                rail_en_oth = 1'b1;
                mcu_rst_n   = 1'b1;
                drive_en    = 1'b1;
            end
            ST_SAFE: rail_en_oth = !kill_q;
            default: ;
        endcase
    end

    assign dev_state   = state_q;
    assign irq_mcu_pwr = irqm_q;
    assign irq_soc_pwr = irqs_q;

    // R8
    release_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MCU_ONLY && !ack_q) |=> state_q != ST_ACTIVE);
    // R7
    soc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_soc_pwr |-> (state_q == ST_MCU_ONLY && !soc_rst_n && drive_en && rail_en_mcu));
    // R11
    uv_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_uv |=> (state_q == ST_INIT && retry_cnt == '0));
    // R6
    orderly_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ORDERLY && !supply_uv) |=> state_q == ST_SAFE);
    // R10
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAFE && retry_cnt >= rcv_limit && !supply_uv) |=> state_q == ST_SAFE);
endmodule

// File: tb/sim_rail_fault_ctrl.sv
module sim_rail_fault_ctrl;
    localparam int N = 8;
    localparam int WW = 8;
    localparam int CW = 3;
    localparam int SL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] f_pg = '0, f_sh = '0, f_il = '0;
    logic [2*N-1:0] grp = 16'h0024;
    logic [1:0] t_m = 2'b00, t_s = 2'b11, t_o = 2'b01;
    logic [WW-1:0] win = 8'd5;
    logic [CW-1:0] lim = 3'd2;
    logic uv = 1'b0, sa = 1'b1, sb = 1'b1;

    logic [2:0] st;
    logic e_m, e_s, e_o, r_m, r_s, drv, i_m, i_s;
    logic [CW-1:0] rc;

    int n_chk = 0, n_fail = 0;
    int m_state = 0, m_cnt = 0, m_tmr = 0, m_pulse = 0;
    bit m_ack = 0, m_kill = 0, m_irqm = 0, m_irqs = 0;

    always #5 clk = ~clk;

    rail_fault_ctrl #(.N_RAILS(N), .WIN_W(WW), .CNT_W(CW), .SRST_LEN(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .flt_pg(f_pg), .flt_short(f_sh), .flt_ilim(f_il),
        .rail_grp(grp), .trig_mcu(t_m), .trig_soc(t_s), .trig_oth(t_o),
        .rcv_window(win), .rcv_limit(lim), .supply_uv(uv), .sleep_a(sa), .sleep_b(sb),
        .dev_state(st), .rail_en_mcu(e_m), .rail_en_soc(e_s), .rail_en_oth(e_o),
        .mcu_rst_n(r_m), .soc_rst_n(r_s), .drive_en(drv), .irq_mcu_pwr(i_m),
        .irq_soc_pwr(i_s), .retry_cnt(rc)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // reference model, one clock edge
    task automatic model_step();
        bit gm, gs, go, any, bad, rec;
        bit [3:0] want;
        int pre, nt;
        if (!rst_n || uv) begin
            m_state = 0; m_cnt = 0; m_tmr = 0; m_pulse = 0;
            m_ack = 0; m_kill = 0; m_irqm = 0; m_irqs = 0;
            return;
        end
        pre = m_state;
        m_irqm = 0; m_irqs = 0;
        nt = (pre == 3) ? ((m_tmr == 255) ? 255 : m_tmr + 1) : 0;
        if (m_pulse != 0) m_pulse--;
        case (pre)
            0: begin m_state = 1; m_kill = 0; m_ack = 0; end
            1, 2: begin
                gm = 0; gs = 0; go = 0;
                for (int i = 0; i < N; i++) begin
                    bad = f_pg[i] | f_sh[i] | f_il[i];
                    if (grp[2*i +: 2] == 2'b00) gm |= bad;
                    else if (grp[2*i +: 2] == 2'b01) gs |= bad;
                    else go |= bad;
                end
                if (pre == 2) gs = 0;
                want = 0;
                if (gm) want[t_m] = 1;
                if (gs) want[t_s] = 1;
                if (go) want[t_o] = 1;
                if (want[0]) begin m_state = 3; m_irqm = 1; end
                else if (want[2]) begin m_state = 3; m_irqm = 1; m_kill = 1; end
                else if (want[3]) begin m_state = 2; m_irqs = 1; m_pulse = SL; m_ack = 0; end
                else if (want[1]) m_state = 4;
                else if (pre == 2) begin
                    if (m_ack && sa) begin m_state = 1; m_ack = 0; end
                    else if (!sa && sb) m_ack = 1;
                end
            end
            4: m_state = 3;
            default: begin
                any = |{f_pg, f_sh, f_il};
                rec = !any && (m_tmr < int'(win)) && (m_cnt < int'(lim));
                if (rec) begin
                    m_state = 0;
                    if (m_cnt < 7) m_cnt++;
                end
            end
        endcase
        m_tmr = nt;
    endtask

    task automatic compare_all();
        bit xm, xs, xo, xrm, xrs, xd;
        xm = 0; xs = 0; xo = 0; xrm = 0; xrs = 0; xd = 0;
        case (m_state)
            1: begin xm = 1; xs = 1; xo = 1; xrm = 1; xrs = (m_pulse == 0); xd = 1; end
            2: begin xm = 1; xo = 1; xrm = 1; xrs = (m_pulse == 0); xd = 1; end
            4: begin xm = 1; xo = 1; xrm = 1; xd = 1; end
            3: xo = !m_kill;
            default: ;
        endcase
        chk("R3", "state", st, m_state);
        chk("R4", "rails", {e_m, e_s, e_o}, {xm, xs, xo});
        chk("R7", "resets", {r_m, r_s}, {xrm, xrs});
        chk("R5", "drive", drv, xd);
        chk("R12", "irqs", {i_m, i_s}, {m_irqm, m_irqs});
        chk("R9", "retry", rc, m_cnt);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        f_pg = '0; f_sh = '0; f_il = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog act=0 exp=1");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        tick(); tick();
        // R1 reset state
        chk("R1", "reset state", st, 0);
        chk("R1", "reset outs", {e_m, e_s, e_o, r_m, r_s, drv, i_m, i_s}, 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "init to active", st, 1);
        chk("R1", "active rails", {e_m, e_s, e_o, r_m, r_s, drv}, 6'b111111);
        // R2 R4 immediate from MCU group via current-limit flag
        f_il[0] = 1'b1; tick(); quiet();
        chk("R4", "imm state", st, 3);
        chk("R4", "imm outs", {e_m, e_s, e_o, r_m, r_s, drv, i_m}, 7'b0010001);
        tick();
        chk("R4", "irq one cycle", i_m, 0);
        chk("R9", "recover init", st, 0);
        chk("R9", "count up", rc, 1);
        tick();
        // R7 SoC error via short flag
        f_sh[1] = 1'b1; tick(); quiet();
        chk("R7", "socerr state", st, 2);
        chk("R7", "socerr outs", {e_m, e_s, e_o, r_m, r_s, drv, i_s}, 7'b1011011);
        tick(); tick(); tick();
        chk("R7", "soc reset still low", r_s, 0);
        tick();
        chk("R7", "soc reset released", r_s, 1);
        // R13 SoC fault ignored in MCU_ONLY
        f_pg[1] = 1'b1; tick(); quiet();
        chk("R13", "soc fault ignored", {st, i_s, i_m}, {3'd2, 2'b00});
        // R8 handshake
        tick();
        chk("R8", "no ack hold", st, 2);
        sa = 0; sb = 0; tick(); sa = 1; sb = 1; tick();
        chk("R8", "wrong ack", st, 2);
        sa = 0; sb = 1; tick();
        chk("R8", "ack wait", st, 2);
        sa = 1; tick();
        chk("R8", "release", {st, e_s}, {3'd1, 1'b1});
        // R6 orderly from other group
        f_pg[2] = 1'b1; tick(); quiet();
        chk("R6", "orderly outs", {st, e_m, e_s, e_o, r_m, r_s, drv}, {3'd4, 6'b101101});
        tick();
        chk("R6", "orderly to safe", st, 3);
        tick(); tick();
        // R10 limit reached (count 2)
        f_il[0] = 1'b1; tick(); quiet();
        tick(); tick(); tick();
        chk("R10", "limit hold", {st, rc}, {3'd3, 3'd2});
        // R11 undervoltage
        uv = 1; tick();
        chk("R11", "uv init", {st, rc}, {3'd0, 3'd0});
        tick();
        chk("R11", "uv held", st, 0);
        uv = 0; tick();
        // R12 MCU error beats SoC error and orderly
        t_m = 2'b11; t_s = 2'b01; t_o = 2'b10;
        f_pg[0] = 1; f_pg[1] = 1; f_pg[2] = 1; tick(); quiet();
        chk("R12", "mcu err wins", {st, e_o, i_m}, {3'd3, 1'b0, 1'b1});
        chk("R5", "other killed", e_o, 0);
        tick(); tick();
        t_o = 2'b01;
        f_pg[0] = 1; f_pg[1] = 1; tick(); quiet();
        chk("R12", "soc err beats orderly", st, 2);
        // R13 reaction beats release
        sa = 0; sb = 1; tick();
        t_m = 2'b00; sa = 1; f_sh[0] = 1; tick(); quiet();
        chk("R13", "fault beats release", st, 3);
        tick(); tick();
        // R10 window elapsed
        lim = 7; win = 3;
        f_pg[0] = 1; tick();
        repeat (5) tick();
        quiet(); tick(); tick();
        chk("R10", "window hold", st, 3);
        uv = 1; tick(); uv = 0; tick();
        // R2 R3 random phase
        for (int c = 0; c < 4000; c++) begin
            if (c % 150 == 0) begin
                grp = 16'($urandom);
                t_m = 2'($urandom); t_s = 2'($urandom); t_o = 2'($urandom);
                win = 8'($urandom % 21); lim = 3'($urandom);
            end
            if ($urandom % 10 == 0) begin
                f_pg = ($urandom % 4 == 0) ? N'(1 << ($urandom % N)) : '0;
                f_sh = ($urandom % 4 == 0) ? N'(1 << ($urandom % N)) : '0;
                f_il = ($urandom % 4 == 0) ? N'(1 << ($urandom % N)) : '0;
            end
            uv = ($urandom % 400 == 0);
            if ($urandom % 5 == 0) sa = ~sa;
            sb = ($urandom % 8 != 0);
            tick();
        end
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule